// File: doc/BRIEF.md
# Crosstalk Test Stimulus Chain

This block is a chain of input-side test cells placed between the primary inputs of a combinational logic block and that block. Each cell holds two registers: a capture stage and an update stage. Depending on the control lines, the capture stages behave as an ordinary serial scan path, as a parallel capture of the pins, as a maximal-length linear feedback shift register that produces pseudo-random patterns, or as a plain shift register that walks a single 1 from the lowest cell to the highest. The update stage latches the capture contents when the update strobe arrives and holds the pattern that is applied to the logic under test.

A crosstalk test run alternates two phases. In the pattern phase the capture chain steps as the LFSR and the result is copied into the update stage. In the selection phase the capture chain is cleared and a single 1 is shifted in at bit 0. With both test controls high, the one input whose capture bit is set is driven by an external square wave, while every other input keeps its latched random value. The oscillating stimulus therefore visits each input in turn while the rest of the pattern stays steady. With the test control low, the pins pass straight through.

Top module: `xt_stim_chain`

## Requirements
- R1: On synchronous reset the update stage clears to all zeros and the capture stage loads the `SEED` parameter, or the value 1 (only bit 0 set) when `SEED` is zero.
- R2: With `cap_en`=1 and `lfsr_mode`=1 the capture stage shifts one place toward the highest bit, and bit 0 takes the XOR of the tapped bits of the old state. For width 8 the taps are bits 7, 5, 4 and 3. For width 4 they are bits 3 and 0, which is the trinomial 1 + x + x^4 in reciprocal form. From any nonzero state the sequence repeats after exactly 2^WIDTH - 1 steps.
- R3: An LFSR step taken from an all-zero capture stage loads the safe seed from R1 instead of staying at zero.
- R4: When `upd_en`=1 the update stage copies the capture stage at that clock edge. Otherwise the update stage holds its value.
- R5: Each drive line i equals `pins[i]` when `test_mode`=0. When `test_mode`=1 it equals `sq_wave` if capture bit i is 1 and `couple_mode`=1, and it equals update bit i in every other case.
- R6: With `cap_en`=1, `lfsr_mode`=0 and `load_sel`=1 the capture stage shifts toward the highest bit, `scan_in` enters bit 0, and `scan_out` always shows the highest capture bit.
- R7: With `cap_en`=1, `lfsr_mode`=0 and `load_sel`=0 the capture stage loads `pins` in parallel.
- R8: A single 1 shifted in at bit 0, followed by shifts with `scan_in`=0, moves up one position per step and leaves the chain after bit WIDTH-1. With `test_mode` and `couple_mode` high, at most one drive line follows `sq_wave` at any time.
- R9: With `cap_en`=0 the capture stage holds, whatever the mode, pin and serial inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Capture stage strobe, one step per cycle while high |
| upd_en | input | 1 | Update stage strobe |
| lfsr_mode | input | 1 | 1: capture stage steps as LFSR |
| load_sel | input | 1 | With lfsr_mode=0: 1 serial shift, 0 parallel pin capture |
| test_mode | input | 1 | 0: pins pass through to the drive lines |
| couple_mode | input | 1 | 1: selected input takes the square wave |
| sq_wave | input | 1 | Oscillating stimulus |
| pins | input | WIDTH | Primary input pins |
| scan_in | input | 1 | Serial input to capture bit 0 |
| drive | output | WIDTH | Lines to the logic under test |
| scan_out | output | 1 | Highest capture bit |

## Verification
Every strobe changes a register at the rising edge after it is raised, and the drive lines are a pure mux over those registers. The bench therefore raises strobes just after a falling edge, drops them after the next rising edge, and reads results at the following falling edge. A capture step shows at `scan_out` one edge later. Capture contents reach `drive` only after a second, separate update strobe, so the bench checks `drive` after that strobe. Changes to `sq_wave`, `pins` or the mode lines are checked a short delay after they are applied, with no clock edge in between.

// File: rtl/xt_pkg.sv
package xt_pkg;

    typedef enum logic [1:0] {
        CAP_HOLD  = 2'd0,
        CAP_LFSR  = 2'd1,
        CAP_SHIFT = 2'd2,
        CAP_PINS  = 2'd3
    } cap_op_e;

    typedef struct packed {
        logic test_mode;
        logic couple_mode;
        logic sq_wave;
    } drive_ctl_t;

    // Feedback mask: bit j set means state bit j joins the XOR.
    function automatic logic [63:0] default_taps(input int w);
        logic [63:0] m;
        case (w)
            2:       m = 64'h3;
            3:       m = 64'h5;
            4:       m = 64'h9;
            5:       m = 64'h12;
            6:       m = 64'h21;
            7:       m = 64'h41;
            8:       m = 64'hB8;
            default: m = (64'd1 << (w - 1)) | 64'd1;
        endcase
        return m;
    endfunction

    function automatic cap_op_e decode_op(input logic en, input logic lfsr,
                                          input logic load);
        if (!en)       return CAP_HOLD;
        else if (lfsr) return CAP_LFSR;
        else if (load) return CAP_SHIFT;
        else           return CAP_PINS;
    endfunction

endpackage

// File: rtl/xt_cap_stage.sv
module xt_cap_stage
    import xt_pkg::*;
#(
    parameter int              WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS = '1,
    parameter logic [WIDTH-1:0] SEED = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  cap_op_e          op,
    input  logic [WIDTH-1:0] pins,
    input  logic             scan_in,
    output logic [WIDTH-1:0] cap_q
);

    logic [WIDTH-1:0] cap_d;
    logic             fb;

    assign fb = ^(cap_q & TAPS);

    always_comb begin
        case (op)
            CAP_LFSR:  cap_d = (cap_q == '0) ? SEED : {cap_q[WIDTH-2:0], fb};
            CAP_SHIFT: cap_d = {cap_q[WIDTH-2:0], scan_in};
            CAP_PINS:  cap_d = pins;
            default:   cap_d = cap_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cap_q <= SEED;
        else     cap_q <= cap_d;
    end

endmodule

// File: rtl/xt_upd_stage.sv
module xt_upd_stage #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic [WIDTH-1:0] cap_q,
    output logic [WIDTH-1:0] upd_q
);

    always_ff @(posedge clk) begin
        if (rst)         upd_q <= '0;
        else if (upd_en) upd_q <= cap_q;
    end

endmodule

// File: rtl/xt_drive_mux.sv
module xt_drive_mux
    import xt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  drive_ctl_t       ctl,
    input  logic [WIDTH-1:0] pins,
    input  logic [WIDTH-1:0] cap_q,
    input  logic [WIDTH-1:0] upd_q,
    output logic [WIDTH-1:0] drive
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        always_comb begin
            if (!ctl.test_mode)                   drive[i] = pins[i];
            else if (cap_q[i] && ctl.couple_mode) drive[i] = ctl.sq_wave;
            else                                  drive[i] = upd_q[i];
        end
    end

endmodule

// File: rtl/xt_stim_chain.sv
module xt_stim_chain
    import xt_pkg::*;
#(
    parameter int               WIDTH    = 8,
    parameter logic [63:0]      TAP_MASK = default_taps(WIDTH),
    parameter logic [WIDTH-1:0] SEED     = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic             upd_en,
    input  logic             lfsr_mode,
    input  logic             load_sel,
    input  logic             test_mode,
    input  logic             couple_mode,
    input  logic             sq_wave,
    input  logic [WIDTH-1:0] pins,
    input  logic             scan_in,
    output logic [WIDTH-1:0] drive,
    output logic             scan_out
);

    localparam logic [WIDTH-1:0] TAPS      = TAP_MASK[WIDTH-1:0];
    localparam logic [WIDTH-1:0] ONE       = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] SAFE_SEED = (SEED == '0) ? ONE : SEED;

    cap_op_e          op;
    drive_ctl_t       ctl;
    logic [WIDTH-1:0] cap_q;
    logic [WIDTH-1:0] upd_q;

    assign op  = decode_op(cap_en, lfsr_mode, load_sel);
    assign ctl = '{test_mode: test_mode, couple_mode: couple_mode, sq_wave: sq_wave};

    xt_cap_stage #(.WIDTH(WIDTH), .TAPS(TAPS), .SEED(SAFE_SEED)) cap_i (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .pins    (pins),
        .scan_in (scan_in),
        .cap_q   (cap_q)
    );

    xt_upd_stage #(.WIDTH(WIDTH)) upd_i (
        .clk    (clk),
        .rst    (rst),
        .upd_en (upd_en),
        .cap_q  (cap_q),
        .upd_q  (upd_q)
    );

    xt_drive_mux #(.WIDTH(WIDTH)) mux_i (
        .ctl   (ctl),
        .pins  (pins),
        .cap_q (cap_q),
        .upd_q (upd_q),
        .drive (drive)
    );

    assign scan_out = cap_q[WIDTH-1];

endmodule

// File: rtl/xt_stim_chain_chk.sv
module xt_stim_chain_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cap_en,
    input logic             upd_en,
    input logic             lfsr_mode,
    input logic             load_sel,
    input logic             test_mode,
    input logic             couple_mode,
    input logic             scan_in,
    input logic [WIDTH-1:0] cap_q,
    input logic [WIDTH-1:0] upd_q,
    input logic [WIDTH-1:0] drive
);

    a_r3_lfsr_never_zero: assert property (@(posedge clk) disable iff (rst)
        (cap_en && lfsr_mode) |=> (cap_q != '0));

    a_r4_update_copies: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> (upd_q == $past(cap_q)));

    a_r4_update_holds: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(upd_q));

    a_r9_capture_holds: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(cap_q));

    a_r8_walk_moves_up: assert property (@(posedge clk) disable iff (rst)
        (cap_en && !lfsr_mode && load_sel && !scan_in && $onehot(cap_q) && !cap_q[WIDTH-1])
        |=> ($onehot(cap_q) && (cap_q == ($past(cap_q) << 1))));

    a_r5_latched_value_out: assert property (@(posedge clk) disable iff (rst)
        (test_mode && !couple_mode) |-> (drive == upd_q));

endmodule

bind xt_stim_chain xt_stim_chain_chk #(.WIDTH(WIDTH)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cap_en      (cap_en),
    .upd_en      (upd_en),
    .lfsr_mode   (lfsr_mode),
    .load_sel    (load_sel),
    .test_mode   (test_mode),
    .couple_mode (couple_mode),
    .scan_in     (scan_in),
    .cap_q       (cap_q),
    .upd_q       (upd_q),
    .drive       (drive)
);

// File: tb/xt_stim_chain_tb.sv
module xt_stim_chain_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cap_en = 1'b0, upd_en = 1'b0, lfsr_mode = 1'b0, load_sel = 1'b0;
    logic         test_mode = 1'b0, couple_mode = 1'b0, sq_wave = 1'b0, scan_in = 1'b0;
    logic [W-1:0] pins = '0;
    logic [W-1:0] drive;
    logic         scan_out;

    int n_chk = 0;
    int n_bad = 0;

    logic [W-1:0] m_cap, m_upd;

    always #5 clk = ~clk;

    xt_stim_chain #(.WIDTH(W), .SEED(8'h00)) dut_i (
        .clk(clk), .rst(rst), .cap_en(cap_en), .upd_en(upd_en),
        .lfsr_mode(lfsr_mode), .load_sel(load_sel), .test_mode(test_mode),
        .couple_mode(couple_mode), .sq_wave(sq_wave), .pins(pins),
        .scan_in(scan_in), .drive(drive), .scan_out(scan_out)
    );

    // Taps 7,5,4,3 for width 8; all-zero state reloads seed 1.
    function automatic logic [W-1:0] lfsr_next(input logic [W-1:0] s);
        if (s == '0) return 8'h01;
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One capture step; result visible at the next falling edge.
    task automatic cap_step(input logic lm, input logic ls, input logic si);
        @(negedge clk);
        lfsr_mode = lm; load_sel = ls; scan_in = si; cap_en = 1'b1;
        @(posedge clk);
        #1 cap_en = 1'b0;
        if (lm)      m_cap = lfsr_next(m_cap);
        else if (ls) m_cap = {m_cap[W-2:0], si};
        else         m_cap = pins;
        @(negedge clk);
    endtask

    task automatic upd_step();
        @(negedge clk);
        upd_en = 1'b1;
        @(posedge clk);
        #1 upd_en = 1'b0;
        m_upd = m_cap;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [W-1:0] pat;
        int           first_ret;
        void'($urandom(32'h1A2B3C));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_cap = 8'h01; m_upd = '0;

        // R1: reset state, zero seed replaced by 1
        test_mode = 1'b1; couple_mode = 1'b0;
        #1 check("R1 update cleared", drive, 8'h00);
        check("R1 scan_out of seed", scan_out, 1'b0);
        upd_step();
        check("R1 safe seed", drive, 8'h01);

        // R2: LFSR sequence and period
        first_ret = 0;
        for (int i = 1; i <= 255; i++) begin
            cap_step(1'b1, 1'b1, 1'b0);
            upd_step();
            check("R2 lfsr state", drive, m_upd);
            check("R6 scan_out msb", scan_out, m_cap[W-1]);
            if (drive == 8'h01 && first_ret == 0) first_ret = i;
        end
        check("R2 period", first_ret, 255);

        // R6: random serial shifting
        for (int i = 0; i < 16; i++) begin
            cap_step(1'b0, 1'b1, 1'($urandom_range(0, 1)));
            check("R6 serial shift", scan_out, m_cap[W-1]);
        end
        upd_step();
        check("R6 shifted contents", drive, m_upd);

        // R7 and R5: pin capture, pass-through
        for (int i = 0; i < 4; i++) begin
            pins = W'($urandom);
            cap_step(1'b0, 1'b0, 1'b0);
            upd_step();
            check("R7 pin capture", drive, m_upd);
            test_mode = 1'b0; couple_mode = 1'b1; sq_wave = 1'b1;
            pins = W'($urandom);
            #1 check("R5 pins pass", drive, pins);
            test_mode = 1'b1; couple_mode = 1'b0;
            #1 check("R5 update value with sq high", drive, m_upd);
            sq_wave = 1'b0;
        end

        // R9: hold while capture strobe is low
        @(negedge clk);
        lfsr_mode = 1'b1; load_sel = 1'b0; scan_in = 1'b1; pins = ~m_cap;
        repeat (3) @(negedge clk);
        check("R9 hold scan_out", scan_out, m_cap[W-1]);
        upd_step();
        check("R9 hold contents", drive, m_upd);

        // R3: LFSR step from zero
        for (int i = 0; i < W; i++) cap_step(1'b0, 1'b1, 1'b0);
        cap_step(1'b1, 1'b1, 1'b0);
        upd_step();
        check("R3 zero reload", drive, 8'h01);

        // R8: walking one over a random pattern
        for (int i = 0; i < 5; i++) cap_step(1'b1, 1'b1, 1'b0);
        upd_step();
        pat = m_upd;
        for (int i = 0; i < W; i++) cap_step(1'b0, 1'b1, 1'b0);
        cap_step(1'b0, 1'b1, 1'b1);
        couple_mode = 1'b1;
        for (int k = 0; k <= W; k++) begin
            logic [W-1:0] lo, hi, e0, e1;
            sq_wave = 1'b0; #1 lo = drive;
            sq_wave = 1'b1; #1 hi = drive;
            e0 = pat; e1 = pat;
            if (k < W) begin e0[k] = 1'b0; e1[k] = 1'b1; end
            check("R8 walk sq low", lo, e0);
            check("R8 walk sq high", hi, e1);
            check("R8 onehot sq lines", $countones(lo ^ hi) <= 1, 1'b1);
            if (k < W) cap_step(1'b0, 1'b1, 1'b0);
        end
        couple_mode = 1'b0;
        #1 check("R4 update unchanged by walk", drive, pat);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule